// File: doc/BRIEF.md
# Priority-Nesting Interrupt Acknowledge Unit

This block keeps an 8-bit status byte and decides, every clock, whether one of its maskable interrupt request lines is taken. Each request line has a 2-bit priority code, where 0 is the most urgent. A request is taken only when the global enable bit is set and the request's code is no larger than the 2-bit service level held in the status byte. When a request is taken, the unit pushes the whole status byte onto a small internal save stack and clears the global enable. It then lowers the service level, so that a request of the same or a less urgent code cannot nest on top of the one being served.

Software-side strobes act on the same byte. They set or clear the enable, take a trap, push the byte, restore it from the stack (return-from-interrupt, return-from-trap or plain pop), or overwrite it as a whole. The byte's other bits (zero, carry, auxiliary carry and the two bank-select bits) are only stored, written and restored here.

Top module: `irq_nest_ctl`

## Requirements
- R1: After reset the status byte is 0x06: enable bit 0 and service level 3. The acknowledge pulse, the overflow flag and the underflow flag are all 0.
- R2: The status byte layout is bit 7 enable, bit 6 zero, bit 5 bank-select high, bit 4 auxiliary carry, bit 3 bank-select low, bits 2:1 service level, bit 0 carry. A byte write loads all eight bits in the next cycle. With no operation, the byte holds.
- R3: `en_set` sets bit 7 and `en_clr` clears bit 7, leaving every other bit unchanged. When both are asserted, set wins.
- R4: A request is eligible only while bit 7 is 1 and its priority code is numerically less than or equal to the service level.
- R5: Among eligible requests, the one with the lowest priority code wins, and ties go to the lowest index. `ack_o` is high for exactly the one cycle after the decision, with the winner on `ack_idx_o`.
- R6: On an acknowledge, the old byte is pushed. In the same cycle as `ack_o`, bit 7 reads 0 and the service level reads code−1, or 0 when the code is 0. Bits 6:3 and bit 0 are kept.
- R7: A trap strobe pushes the byte and clears bit 7, keeping all other bits.
- R8: A save strobe pushes the byte and leaves it unchanged.
- R9: Each of the three restore strobes loads the byte from the top of the stack and pops it (last in, first out).
- R10: A push onto a full stack discards the entry and pulses `ovf_o` for one cycle. The byte update of that operation still takes place.
- R11: A restore from an empty stack loads 0x06 and pulses `unf_o` for one cycle.
- R12: Only one operation acts per cycle, in the order acknowledge, trap, save, restore, byte write, enable set, enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_REQ | Interrupt request lines |
| prio_i | input | 2*N_REQ | Priority code per line, line k in bits 2k+1:2k |
| en_set | input | 1 | Set enable bit |
| en_clr | input | 1 | Clear enable bit |
| trap_i | input | 1 | Software trap strobe |
| save_i | input | 1 | Push status byte |
| ret_irq_i | input | 1 | Return from interrupt (restore) |
| ret_trap_i | input | 1 | Return from trap (restore) |
| pop_i | input | 1 | Pop status byte (restore) |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| stat_o | output | 8 | Status byte |
| ack_o | output | 1 | Acknowledge pulse |
| ack_idx_o | output | IDX_W | Acknowledged request index |
| ovf_o | output | 1 | Stack overflow pulse |
| unf_o | output | 1 | Stack underflow pulse |

## Verification
The bench builds the unit with five request lines and a four-entry stack. Five lines give index ties at every priority code, and the odd count exercises a non-power-of-two arbiter. The shallow stack makes overflow and underflow frequent under random strobes. Directed runs on top of that nest acknowledges level by level, fill the stack past its depth, and drain it below empty.

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl #(
  parameter int N_REQ     = 8,
  parameter int STK_DEPTH = 8,
  parameter int IDX_W     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_REQ-1:0]   req_i,
  input  logic [2*N_REQ-1:0] prio_i,
  input  logic               en_set,
  input  logic               en_clr,
  input  logic               trap_i,
  input  logic               save_i,
  input  logic               ret_irq_i,
  input  logic               ret_trap_i,
  input  logic               pop_i,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         stat_o,
  output logic               ack_o,
  output logic [IDX_W-1:0]   ack_idx_o,
  output logic               ovf_o,
  output logic               unf_o
);
  localparam int SP_W  = $clog2(STK_DEPTH + 1);
  localparam int PTR_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
  localparam logic [7:0] RST_VAL = 8'h06;

  logic [7:0]       stat_q;
  logic [7:0]       stk [STK_DEPTH];
  logic [SP_W-1:0]  sp;
  logic             found;
  logic [1:0]       best_p;
  logic [IDX_W-1:0] best_i;

  always_comb begin
    found  = 1'b0;
    best_p = 2'd3;
    best_i = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && prio_i[2*i +: 2] <= stat_q[2:1] &&
          (!found || prio_i[2*i +: 2] < best_p)) begin
        found  = 1'b1;
        best_p = prio_i[2*i +: 2];
        best_i = IDX_W'(i);
      end
    end
  end

  wire take    = stat_q[7] & found;
  wire do_trap = !take & trap_i;
  wire do_save = !take & !trap_i & save_i;
  wire push    = take | trap_i | save_i;
  wire restore = !push & (ret_irq_i | ret_trap_i | pop_i);
  wire do_wr   = !push & !restore & wr_en;
  wire do_set  = !push & !restore & !wr_en & en_set;
  wire do_clr  = !push & !restore & !wr_en & !en_set & en_clr;
  wire full    = (sp == SP_W'(STK_DEPTH));
  wire empty   = (sp == '0);
  wire [SP_W-1:0] sp_dn = sp - SP_W'(1);
  wire [1:0] new_lvl = (best_p == 2'd0) ? 2'd0 : best_p - 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= RST_VAL;
      sp        <= '0;
      ack_o     <= 1'b0;
      ack_idx_o <= '0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
    end else begin
      ack_o     <= take;
      ack_idx_o <= take ? best_i : '0;
      ovf_o     <= push & full;
      unf_o     <= restore & empty;
      if (push && !full) begin
        stk[sp[PTR_W-1:0]] <= stat_q;
        sp <= sp + SP_W'(1);
      end
      if (take)          stat_q <= {1'b0, stat_q[6:3], new_lvl, stat_q[0]};
      else if (do_trap)  stat_q <= {1'b0, stat_q[6:0]};
      else if (do_save)  stat_q <= stat_q;
      else if (restore) begin
        if (empty) stat_q <= RST_VAL;
        else begin
          stat_q <= stk[sp_dn[PTR_W-1:0]];
          sp     <= sp_dn;
        end
      end
      else if (do_wr)    stat_q <= wr_data;
      else if (do_set)   stat_q[7] <= 1'b1;
      else if (do_clr)   stat_q[7] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R6
  ack_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !stat_q[7]);
  // R4
  ack_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(stat_q[7]));
  // R6
  lvl_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> stat_q[2:1] <= $past(stat_q[2:1]));
  // R10
  ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(sp) == SP_W'(STK_DEPTH) && $stable(sp));
  // R11
  unf_loads_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> stat_q == RST_VAL && sp == '0);
  // R12
  ovf_unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));
  // R5
  ack_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> 32'(ack_idx_o) < N_REQ);
endmodule

// File: tb/irq_nest_ctl_bench.sv
module irq_nest_ctl_bench;
  localparam int NR = 5;
  localparam int SD = 4;
  localparam int IW = $clog2(NR);

  logic clk = 0, rst_n = 0;
  logic [NR-1:0]   req = '0;
  logic [2*NR-1:0] prio = '0;
  logic en_set = 0, en_clr = 0, trap = 0, save = 0, rti = 0, rtt = 0, pop = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] stat;
  logic ack, ovf, unf;
  logic [IW-1:0] idx;

  irq_nest_ctl #(.N_REQ(NR), .STK_DEPTH(SD)) u_irq_nest_ctl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
    .en_set(en_set), .en_clr(en_clr), .trap_i(trap), .save_i(save),
    .ret_irq_i(rti), .ret_trap_i(rtt), .pop_i(pop), .wr_en(wr_en), .wr_data(wr_data),
    .stat_o(stat), .ack_o(ack), .ack_idx_o(idx), .ovf_o(ovf), .unf_o(unf));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] m_stat;
  logic [7:0] m_stk [SD];
  int m_sp;
  logic e_ack, e_ovf, e_unf;
  int e_idx;
  string tag;

  function automatic int pick(logic [7:0] s, logic [NR-1:0] r, logic [2*NR-1:0] p);
    int best = -1;
    if (!s[7]) return -1;
    for (int i = 0; i < NR; i++)
      if (r[i] && p[2*i +: 2] <= s[2:1] && (best < 0 || p[2*i +: 2] < p[2*best +: 2]))
        best = i;
    return best;
  endfunction

  function automatic int nops();
    return int'(trap) + int'(save) + int'(rti | rtt | pop) + int'(wr_en) + int'(en_set) + int'(en_clr);
  endfunction

  task automatic model_step();
    int w = pick(m_stat, req, prio);
    logic do_push, do_rest;
    do_push = (w >= 0) || trap || save;
    do_rest = !do_push && (rti || rtt || pop);
    e_ack = (w >= 0); e_idx = (w >= 0) ? w : 0;
    e_ovf = do_push && m_sp == SD;
    e_unf = do_rest && m_sp == 0;
    if (do_push && m_sp < SD) begin m_stk[m_sp] = m_stat; m_sp++; end
    if (w >= 0) begin
      logic [1:0] c = prio[2*w +: 2];
      m_stat[7] = 0; m_stat[2:1] = (c == 0) ? 2'd0 : c - 2'd1; tag = "R6";
    end else if (trap) begin m_stat[7] = 0; tag = "R7"; end
    else if (save) tag = e_ovf ? "R10" : "R8";
    else if (do_rest) begin
      if (m_sp == 0) begin m_stat = 8'h06; tag = "R11"; end
      else begin m_sp--; m_stat = m_stk[m_sp]; tag = "R9"; end
    end
    else if (wr_en) begin m_stat = wr_data; tag = "R2"; end
    else if (en_set) begin m_stat[7] = 1; tag = "R3"; end
    else if (en_clr) begin m_stat[7] = 0; tag = "R3"; end
    else tag = "R2";
    if (nops() + int'(w >= 0) > 1) tag = "R12";
  endtask

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic clear_in();
    req = '0; en_set = 0; en_clr = 0; trap = 0; save = 0; rti = 0; rtt = 0; pop = 0; wr_en = 0;
  endtask

  // drive current inputs for one edge, then compare at the next falling edge
  task automatic cycle();
    model_step();
    @(negedge clk);
    chk(tag, int'(stat), int'(m_stat));
    chk(e_ack ? "R5" : "R4", int'(ack), int'(e_ack));
    if (e_ack) chk("R5", int'(idx), e_idx);
    chk("R10", int'(ovf), int'(e_ovf));
    chk("R11", int'(unf), int'(e_unf));
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    m_stat = 8'h06; m_sp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(stat), 8'h06);
    chk("R1", int'(ack), 0);
    chk("R1", int'(ovf | unf), 0);
    rst_n = 1;
    // R2 write whole byte with level 3 and enable
    wr_en = 1; wr_data = 8'hFF; cycle(); clear_in();
    // R5 tie on lowest code -> lowest index; nest down levels (R6)
    req = 5'b11110; prio = {2'd2, 2'd1, 2'd1, 2'd3, 2'd3}; cycle(); clear_in();
    en_set = 1; cycle(); clear_in();
    req = 5'b11111; prio = {2'd2, 2'd1, 2'd0, 2'd1, 2'd3}; cycle(); clear_in();
    // R4 level 0 after code 0: code 1 not allowed, code 0 allowed
    en_set = 1; cycle(); clear_in();
    req = 5'b00001; prio = {2'd0, 2'd0, 2'd0, 2'd0, 2'd1}; cycle(); clear_in();
    req = 5'b10000; prio = '0; cycle(); clear_in();
    // R10 overflow by saves, R11 underflow by pops
    repeat (SD + 2) begin save = 1; cycle(); end
    clear_in();
    repeat (SD + 3) begin pop = 1; cycle(); end
    clear_in();
    // R12 collisions: trap with write and pop
    trap = 1; wr_en = 1; wr_data = 8'h80; pop = 1; cycle(); clear_in();
    // R3 set and clear together
    en_set = 1; en_clr = 1; cycle(); clear_in();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      req = NR'($urandom);
      prio = (2*NR)'($urandom);
      en_set = ($urandom % 4) == 0;
      en_clr = ($urandom % 10) == 0;
      trap = ($urandom % 16) == 0;
      save = ($urandom % 12) == 0;
      rti = ($urandom % 10) == 0;
      rtt = ($urandom % 20) == 0;
      pop = ($urandom % 20) == 0;
      wr_en = ($urandom % 12) == 0;
      wr_data = 8'($urandom);
      cycle();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule